// File: doc/BRIEF.md
# Wake Event Power Management Controller

This block keeps the power state and the wake-up request of a network function that sits on a PCI-style configuration bus. Software reaches two 32-bit registers through simple configuration reads and writes:

- A power control/status register sets the current power state and the wake request enable. It also reports the latched wake status.
- A wake-source register arms any of three sources: a change of the link status, a magic-packet detection, and a wake-frame match.

The event inputs come from monitors that run on another clock. Each input is synchronised into the local clock and reduced to a one-cycle pulse. An armed pulse sets a sticky status bit. While both the status bit and the request enable are 1, the block pulls the active-low, open-drain wake request line low. It does this by asserting an output enable, and the pad pulls the line low. The request stays low until software clears the status bit by writing 1 to it, or clears the enable. Only the full-power state D0 and the sleep state D3 are accepted. In D3, configuration accesses and wake detection keep working, so software can bring the function back to D0.

Top module: `wake_pm_ctrl`

## Requirements
- R1: After reset, the power state is D0 (code 00), the wake status, the request enable and all three source arms read 0, `wake_oe` is 0 and `wake_n` is 1.
- R2: The control/status register is at address 0x54. Bits 1:0 hold the power state, bit 8 the request enable, and bit 15 the wake status. All other bits read 0. A write updates bit 8 and, where legal, bits 1:0.
- R3: A write of state code 01 or 10 leaves the power state unchanged. The power state only ever holds 00 (D0) or 11 (D3).
- R4: The wake-source register is at address 0x40. Bit 29 arms link-change wake, bit 28 arms wake-frame wake, and bit 27 arms magic-packet wake. These bits read back as written, and every other bit reads 0.
- R5: A rising edge on `magic_hit` or `frame_hit` sets the wake status on the third rising clock edge after the input changes, but only when that source is armed. An unarmed source leaves the status unchanged.
- R6: When link wake is armed, a change of `link_up` in either direction sets the wake status with the same three-edge latency.
- R7: The wake status stays set until a control/status write carries 1 in bit 15. A write with 0 in bit 15 leaves the status unchanged.
- R8: `wake_oe` is 1, and `wake_n` is 0, exactly while the wake status and the request enable are both 1. Clearing either one releases the line on the next edge.
- R9: Configuration reads and writes, and wake detection, behave the same in D3 as in D0.
- R10: If an armed event pulse and a status-clearing write fall on the same clock edge, the status ends up set, so the event is not lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset; returns to D0 |
| cfg_wr | input | 1 | Configuration write strobe, one cycle per write |
| cfg_rd | input | 1 | Configuration read strobe; data is valid in the same cycle |
| cfg_addr | input | 8 | Byte address of the register |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data; zero when no register is read |
| link_up | input | 1 | Link status level from the link monitor, asynchronous |
| magic_hit | input | 1 | Magic-packet detection, asynchronous; must be held at least two clocks |
| frame_hit | input | 1 | Wake-frame match, asynchronous; must be held at least two clocks |
| pwr_state | output | 2 | Current power state (00 = D0, 11 = D3) |
| wake_oe | output | 1 | Output enable for the open-drain pad that pulls the wake line low |
| wake_n | output | 1 | Active-low wake request level |

## Verification
An armed event that sets the status and a software write that clears it by writing 1 can arrive on the same clock edge. The bench provokes this by changing `link_up` two cycles before it issues the clearing write, so the synchronised pulse lands on the edge of that write. It then reads the register and expects the status still set. A plain clearing write with no event follows, to show that the clear itself works and that the status survived only because the two collided.

// File: rtl/wpm_pkg.sv
package wpm_pkg;

  localparam int unsigned N_SRC     = 3;
  localparam int unsigned SRC_LINK  = 0;
  localparam int unsigned SRC_MAGIC = 1;
  localparam int unsigned SRC_FRAME = 2;

  localparam int unsigned EN_BIT = 8;
  localparam int unsigned ST_BIT = 15;

  typedef enum logic [1:0] {
    PS_D0 = 2'b00,
    PS_D3 = 2'b11
  } pstate_e;

  // Bit position of each source's arm flag in the wake-source register.
  function automatic int unsigned sel_bit(input int unsigned idx);
    case (idx)
      SRC_LINK:  return 29;
      SRC_MAGIC: return 27;
      default:   return 28;
    endcase
  endfunction

  // Only the full-power and the sleep encodings are accepted.
  function automatic logic state_write_ok(input logic [1:0] code);
    return (code == PS_D0) || (code == PS_D3);
  endfunction

  // A new hit wins over a clear in the same cycle.
  function automatic logic next_status(input logic cur, input logic hit,
                                       input logic clr);
    return hit | (cur & ~clr);
  endfunction

endpackage

// File: rtl/wpm_sync.sv
module wpm_sync #(
  parameter int unsigned STAGES   = 2,
  parameter bit          ANY_EDGE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic pulse
);

  localparam int unsigned CHAIN_W = STAGES + 1;

  // chain[STAGES-1] is the synchronised level and chain[STAGES] its history.
  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[CHAIN_W-2:0], din};
  end

  logic lvl_now, lvl_old;
  assign lvl_now = chain[STAGES-1];
  assign lvl_old = chain[STAGES];

  generate
    if (ANY_EDGE) begin : g_any
      assign pulse = lvl_now ^ lvl_old;
    end else begin : g_rise
      assign pulse = lvl_now & ~lvl_old;
      // R5: a rising-edge pulse lasts one cycle per edge
      a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
    end
  endgenerate

endmodule

// File: rtl/wpm_csr.sv
module wpm_csr
  import wpm_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter logic [ADDR_W-1:0] CSR_ADDR = 8'h54,
  parameter logic [ADDR_W-1:0] SEL_ADDR = 8'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              status,
  output logic [DATA_W-1:0] rdata,
  output pstate_e           pstate,
  output logic              pme_en,
  output logic [N_SRC-1:0]  arm,
  output logic              clr_req
);

  logic csr_hit, sel_hit, csr_wr, sel_wr;
  assign csr_hit = (addr == CSR_ADDR);
  assign sel_hit = (addr == SEL_ADDR);
  assign csr_wr  = wr & csr_hit;
  assign sel_wr  = wr & sel_hit;
  assign clr_req = csr_wr & wdata[ST_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pstate <= PS_D0;
      pme_en <= 1'b0;
      arm    <= '0;
    end else begin
      if (csr_wr) begin
        pme_en <= wdata[EN_BIT];
        if (state_write_ok(wdata[1:0])) pstate <= pstate_e'(wdata[1:0]);
      end
      if (sel_wr) begin
        for (int i = 0; i < N_SRC; i++) arm[i] <= wdata[sel_bit(i)];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (rd && csr_hit) begin
      rdata[1:0]    = pstate;
      rdata[EN_BIT] = pme_en;
      rdata[ST_BIT] = status;
    end else if (rd && sel_hit) begin
      for (int i = 0; i < N_SRC; i++) rdata[sel_bit(i)] = arm[i];
    end
  end

  // R3: only the two legal encodings are ever held
  a_r3_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == PS_D0) || (pstate == PS_D3));

  // R3: an illegal state write leaves the state alone
  a_r3_state_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && !state_write_ok(wdata[1:0])) |=> $stable(pstate));

endmodule

// File: rtl/wpm_status.sv
module wpm_status
  import wpm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] hit,
  input  logic [N_SRC-1:0] arm,
  input  logic             clr,
  output logic             status,
  output logic             set_now
);

  assign set_now = |(hit & arm);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= 1'b0;
    else        status <= next_status(status, set_now, clr);
  end

  // R7: status is sticky until a clear
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status && !clr) |=> status);

  // R10: an armed hit always leaves the status set, even against a clear
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_now |=> status);

  // R5: no armed hit means no new status
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!status && !set_now) |=> !status);

endmodule

// File: rtl/wake_pm_ctrl.sv
module wake_pm_ctrl
  import wpm_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32,
  parameter logic [ADDR_W-1:0] CSR_ADDR = 8'h54,
  parameter logic [ADDR_W-1:0] SEL_ADDR = 8'h40,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              link_up,
  input  logic              magic_hit,
  input  logic              frame_hit,
  output logic [1:0]        pwr_state,
  output logic              wake_oe,
  output logic              wake_n
);

  logic [N_SRC-1:0] src_raw, src_pulse, arm;
  logic             status, set_now, clr_req, pme_en;
  pstate_e          pstate;

  assign src_raw[SRC_LINK]  = link_up;
  assign src_raw[SRC_MAGIC] = magic_hit;
  assign src_raw[SRC_FRAME] = frame_hit;

  generate
    for (genvar g = 0; g < N_SRC; g++) begin : g_src
      wpm_sync #(
        .STAGES  (SYNC_STAGES),
        .ANY_EDGE(g == SRC_LINK)
      ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (src_raw[g]),
        .pulse(src_pulse[g])
      );
    end
  endgenerate

  wpm_csr #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .CSR_ADDR(CSR_ADDR),
    .SEL_ADDR(SEL_ADDR)
  ) u_csr (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (cfg_wr),
    .rd     (cfg_rd),
    .addr   (cfg_addr),
    .wdata  (cfg_wdata),
    .status (status),
    .rdata  (cfg_rdata),
    .pstate (pstate),
    .pme_en (pme_en),
    .arm    (arm),
    .clr_req(clr_req)
  );

  wpm_status u_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit    (src_pulse),
    .arm    (arm),
    .clr    (clr_req),
    .status (status),
    .set_now(set_now)
  );

  assign pwr_state = pstate;
  assign wake_oe   = status & pme_en;
  assign wake_n    = ~wake_oe;

  // R8: a write that drops the enable releases the line
  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == CSR_ADDR && !cfg_wdata[EN_BIT]) |=> !wake_oe);

  // R8: the request holds while software writes nothing
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_oe && !cfg_wr) |=> wake_oe);

endmodule

// File: tb/wake_pm_ctrl_tb.sv
module wake_pm_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        link_up = 1'b0, magic_hit = 1'b0, frame_hit = 1'b0;
  logic [1:0]  pwr_state;
  logic        wake_oe, wake_n;
  logic        obs_pin = 1'b0;
  bit          done = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;

  localparam logic [7:0] A_CSR = 8'h54;
  localparam logic [7:0] A_SEL = 8'h40;

  typedef struct {
    string       req;
    logic [31:0] exp;
    bit          pin;
  } item_t;
  item_t q[$];

  always #5 clk = ~clk;

  wake_pm_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .link_up(link_up), .magic_hit(magic_hit), .frame_hit(frame_hit),
    .pwr_state(pwr_state), .wake_oe(wake_oe), .wake_n(wake_n)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string r);
    item_t it;
    it.req = r; it.exp = e; it.pin = 1'b0;
    q.push_back(it);
    cfg_rd = 1'b1; cfg_addr = a;
    tick();
    cfg_rd = 1'b0;
  endtask

  // expected {wake_oe, wake_n, pwr_state}
  task automatic pin(input logic [3:0] e, input string r);
    item_t it;
    it.req = r; it.exp = {28'd0, e}; it.pin = 1'b1;
    q.push_back(it);
    obs_pin = 1'b1;
    tick();
    obs_pin = 1'b0;
  endtask

  // monitor: compares in mid-cycle, away from the active edge
  always @(negedge clk) begin
    item_t it;
    logic [31:0] act;
    if (rst_n && (cfg_rd || obs_pin)) begin
      n_cmp++;
      if (q.size() == 0) begin
        n_bad++;
        $display("FAIL scoreboard empty: actual %h expected none", cfg_rdata);
      end else begin
        it  = q.pop_front();
        act = it.pin ? {28'd0, wake_oe, wake_n, pwr_state} : cfg_rdata;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    pin(4'b0100, "R1 pins after reset");
    rd(A_CSR, 32'h0, "R1 control after reset");
    rd(A_SEL, 32'h0, "R1 source arms after reset");

    // R2 enter D3 with enable
    wr(A_CSR, 32'h0000_0103);
    rd(A_CSR, 32'h0000_0103, "R2 control readback");
    pin(4'b0111, "R2 D3 no request");

    // R3 illegal states ignored
    wr(A_CSR, 32'h0000_0102);
    rd(A_CSR, 32'h0000_0103, "R3 code 10 ignored");
    wr(A_CSR, 32'h0000_0101);
    rd(A_CSR, 32'h0000_0103, "R3 code 01 ignored");

    // R4 arm bits
    wr(A_SEL, 32'hFFFF_FFFF);
    rd(A_SEL, 32'h3800_0000, "R4 only arm bits stored");
    wr(A_SEL, 32'h0800_0000);
    rd(A_SEL, 32'h0800_0000, "R4 magic only");

    // R5 unarmed frame source
    frame_hit = 1'b1;
    repeat (4) tick();
    rd(A_CSR, 32'h0000_0103, "R5 unarmed frame ignored");
    frame_hit = 1'b0;

    // R5 / R9 armed magic in D3: status visible after third edge
    magic_hit = 1'b1;
    tick(); tick();
    rd(A_CSR, 32'h0000_0103, "R5 not yet after two edges");
    rd(A_CSR, 32'h0000_8103, "R5 R9 magic sets status in D3");
    pin(4'b1011, "R8 request asserted");
    magic_hit = 1'b0;

    // R7 / R8 drop enable without clearing
    wr(A_CSR, 32'h0000_0003);
    rd(A_CSR, 32'h0000_8003, "R7 status kept when bit 15 is 0");
    pin(4'b0111, "R8 enable cleared releases");
    wr(A_CSR, 32'h0000_0103);
    pin(4'b1011, "R8 re-enable reasserts");
    wr(A_CSR, 32'h0000_8103);
    rd(A_CSR, 32'h0000_0103, "R7 write one clears");
    pin(4'b0111, "R8 status cleared releases");

    // R6 link change both directions
    wr(A_SEL, 32'h2000_0000);
    link_up = 1'b1;
    repeat (3) tick();
    rd(A_CSR, 32'h0000_8103, "R6 link rise");
    wr(A_CSR, 32'h0000_8103);
    rd(A_CSR, 32'h0000_0103, "R7 clear after link rise");
    link_up = 1'b0;
    repeat (3) tick();
    rd(A_CSR, 32'h0000_8103, "R6 link fall");

    // R10 collision: pulse lands on the clearing edge
    link_up = 1'b1;
    tick(); tick();
    wr(A_CSR, 32'h0000_8103);
    rd(A_CSR, 32'h0000_8103, "R10 set wins over clear");
    wr(A_CSR, 32'h0000_8103);
    rd(A_CSR, 32'h0000_0103, "R7 clear without event");

    // R9 back to D0, detection still works
    wr(A_CSR, 32'h0000_0100);
    pin(4'b0100, "R9 back in D0");
    wr(A_SEL, 32'h0800_0000);
    magic_hit = 1'b1;
    repeat (3) tick();
    rd(A_CSR, 32'h0000_8100, "R9 magic in D0");
    pin(4'b1000, "R8 request in D0");
    magic_hit = 1'b0;

    repeat (2) tick();
    if (q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL scoreboard leftover: actual %0d expected 0", q.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule